// File: doc/BRIEF.md
# Operand Effective-Address Generator

This block resolves one operand specifier of a two-address, register-rich 16-bit processor. Each specifier is 6 bits wide: a 3-bit addressing mode sits in bits [5:3] and a 3-bit register number sits in bits [2:0]. There are eight 16-bit registers. Register 7 is the program counter and register 6 is the hardware stack pointer. From the specifier, the block produces an effective address, or it reports that the operand is the register itself. It also requests the register update that the mode implies: post-increment, pre-decrement, or the program counter advancing past an index word.

Bit 3 of the specifier (the low mode bit) selects one level of indirection. Bits [5:4] choose the base form:
- 0: direct
- 1: post-increment
- 2: pre-decrement
- 3: indexed

The block reads registers through a single combinational read port. It fetches index words and deferred pointers through a request/acknowledge memory read port. Register write-back leaves the block as a one-cycle write strobe. Instruction fetch, the ALU, the register file and memory all sit outside the block. A caller pulses `start` with the specifier and waits for `done`. `start` is only taken while the block is idle.

Top module: `opnd_ea_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `done`, `reg_wr_en` and `mem_req` are 0.
- R2: Mode 0 (register direct) raises `done` one cycle after `start`. On that cycle `is_register`=1, `ea` holds the zero-extended register number, and there is no register write and no memory request.
- R3: Mode 1 raises `done` one cycle after `start`, with `ea` equal to the register value, `is_register`=0 and no write-back.
- R4: Mode 2 gives `ea` equal to the register value. It writes back the register plus the step: 1 for a byte operation (`byte_op`=1), 2 for a word operation. The write-back strobe falls in the same cycle as `done`.
- R5: Mode 4 writes back the register minus the step and gives that decremented value as `ea`. It finishes in the same single cycle as R4.
- R6: In modes 2 and 4, registers 6 and 7 always step by 2, even when `byte_op`=1.
- R7: Mode 3 writes back the register plus 2 on the cycle after `start`, whatever `byte_op` is. It then reads memory at the old register value and returns the word read as `ea`.
- R8: Mode 5 writes back the register minus 2, reads memory at that decremented value, and returns the word read as `ea`.
- R9: Mode 6 reads the PC (register 7), fetches the index word X from memory at the PC, and writes PC+2 to register 7. It returns register+X (modulo 2^16) as `ea`. When the register is 7, the base is the advanced PC. The PC write and `done` fall in the same cycle.
- R10: Mode 7 forms the sum as in R9, reads memory at that sum, and returns the word read as `ea`.
- R11: A raised `mem_req` stays high with an unchanged `mem_addr` until `mem_ack` is seen.
- R12: A `start` pulse that arrives while an operand is still being resolved is ignored. It causes no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving `spec` (taken only when idle) |
| spec | input | 6 | Mode in [5:3], register number in [2:0] |
| byte_op | input | 1 | 1 = byte-sized operand, 0 = word |
| reg_rd_idx | output | 3 | Register read index |
| reg_rd_data | input | 16 | Register value for `reg_rd_idx`, same cycle |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 16 | Word read |
| done | output | 1 | One-cycle strobe: result valid |
| ea | output | 16 | Effective address, or register number when `is_register` |
| is_register | output | 1 | Operand is the register itself |
| reg_wr_en | output | 1 | Register write-back strobe |
| reg_wr_idx | output | 3 | Register written |
| reg_wr_data | output | 16 | Value written |

## Verification
The register write-back and the completion strobe share a cycle in two cases: post-increment and pre-decrement register modes, and indexed mode, where the PC advance lands together with `done`. Indexed mode on register 7 adds a further overlap, because the base is the PC value being written in that same cycle. The bench provokes both by running modes 2, 4 and 6 back to back, including on R6 and R7, against a behavioural model that predicts every strobe and value on every clock. It also checks register contents afterwards through its own register file. A `start` pulse injected during a slow memory acknowledge tests that a new request cannot overlap a busy one.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

    localparam int unsigned WORD_W     = 16;
    localparam int unsigned REG_W      = 3;
    localparam int unsigned MODE_W     = 3;
    localparam int unsigned SPEC_W     = MODE_W + REG_W;
    localparam int unsigned WORD_BYTES = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [REG_W-1:0]  ridx_t;

    // base form chosen by the two upper mode bits
    typedef enum logic [1:0] {
        AM_DIRECT  = 2'd0,
        AM_POSTINC = 2'd1,
        AM_PREDEC  = 2'd2,
        AM_INDEX   = 2'd3
    } am_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PCRD,
        ST_XFETCH,
        ST_PTR
    } seq_st_e;

    typedef struct packed {
        am_kind_e kind;
        logic     defer;
        ridx_t    rn;
        word_t    step;
    } spec_dec_t;

    // pointer step: a single byte only for non-deferred byte ops on ordinary registers
    function automatic word_t step_size(input logic byte_op, input logic defer,
                                        input ridx_t rn, input ridx_t sp_idx,
                                        input ridx_t pc_idx);
        if (byte_op && !defer && rn != sp_idx && rn != pc_idx)
            return word_t'(1);
        return word_t'(WORD_BYTES);
    endfunction

endpackage

// File: rtl/opnd_decode.sv
module opnd_decode
    import opnd_pkg::*;
#(
    parameter int unsigned SP_IDX = 6,
    parameter int unsigned PC_IDX = 7
) (
    input  logic [SPEC_W-1:0] spec,
    input  logic              byte_op,
    output spec_dec_t         dec
);
    always_comb begin
        dec.kind  = am_kind_e'(spec[SPEC_W-1 -: 2]);
        dec.defer = spec[REG_W];
        dec.rn    = spec[REG_W-1:0];
        dec.step  = step_size(byte_op, spec[REG_W], spec[REG_W-1:0],
                              ridx_t'(SP_IDX), ridx_t'(PC_IDX));
    end
endmodule

// File: rtl/opnd_ptr_update.sv
module opnd_ptr_update
    import opnd_pkg::*;
(
    input  am_kind_e kind,
    input  word_t    step,
    input  word_t    rval,
    output word_t    use_addr,
    output word_t    new_val
);
    always_comb begin
        unique case (kind)
            AM_POSTINC: begin
                use_addr = rval;
                new_val  = rval + step;
            end
            AM_PREDEC: begin
                new_val  = rval - step;
                use_addr = rval - step;
            end
            default: begin
                use_addr = rval;
                new_val  = rval;
            end
        endcase
    end
endmodule

// File: rtl/opnd_seq.sv
module opnd_seq
    import opnd_pkg::*;
#(
    parameter int unsigned PC_IDX = 7
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  am_kind_e dec_kind,
    input  logic     dec_defer,
    input  ridx_t    dec_rn,
    input  word_t    use_addr,
    input  word_t    new_val,
    output ridx_t    reg_rd_idx,
    input  word_t    reg_rd_data,
    output logic     mem_req,
    output word_t    mem_addr,
    input  logic     mem_ack,
    input  word_t    mem_rdata,
    output logic     done,
    output word_t    ea,
    output logic     is_register,
    output logic     reg_wr_en,
    output ridx_t    reg_wr_idx,
    output word_t    reg_wr_data
);
    localparam ridx_t PC_R = ridx_t'(PC_IDX);

    seq_st_e st_q;
    logic    defer_q;
    ridx_t   rn_q;
    word_t   base_q, pc_q, ptr_q;
    word_t   pc_next, idx_base, idx_sum;

    always_comb begin
        pc_next  = pc_q + word_t'(WORD_BYTES);
        idx_base = (rn_q == PC_R) ? pc_next : base_q;
        idx_sum  = idx_base + mem_rdata;
    end

    assign reg_rd_idx = (st_q == ST_PCRD) ? PC_R : dec_rn;
    assign mem_req    = (st_q == ST_XFETCH) || (st_q == ST_PTR);
    assign mem_addr   = (st_q == ST_XFETCH) ? pc_q : ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            defer_q     <= 1'b0;
            rn_q        <= '0;
            base_q      <= '0;
            pc_q        <= '0;
            ptr_q       <= '0;
            done        <= 1'b0;
            ea          <= '0;
            is_register <= 1'b0;
            reg_wr_en   <= 1'b0;
            reg_wr_idx  <= '0;
            reg_wr_data <= '0;
        end else begin
            done      <= 1'b0;
            reg_wr_en <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        defer_q <= dec_defer;
                        rn_q    <= dec_rn;
                        unique case (dec_kind)
                            AM_DIRECT: begin
                                done        <= 1'b1;
                                is_register <= !dec_defer;
                                ea          <= dec_defer ? reg_rd_data : word_t'(dec_rn);
                            end
                            AM_POSTINC, AM_PREDEC: begin
                                reg_wr_en   <= 1'b1;
                                reg_wr_idx  <= dec_rn;
                                reg_wr_data <= new_val;
                                if (dec_defer) begin
                                    ptr_q <= use_addr;
                                    st_q  <= ST_PTR;
                                end else begin
                                    done        <= 1'b1;
                                    is_register <= 1'b0;
                                    ea          <= use_addr;
                                end
                            end
                            AM_INDEX: begin
                                base_q <= reg_rd_data;
                                st_q   <= ST_PCRD;
                            end
                        endcase
                    end
                end
                ST_PCRD: begin
                    pc_q <= reg_rd_data;
                    st_q <= ST_XFETCH;
                end
                ST_XFETCH: begin
                    if (mem_ack) begin
                        reg_wr_en   <= 1'b1;
                        reg_wr_idx  <= PC_R;
                        reg_wr_data <= pc_next;
                        if (defer_q) begin
                            ptr_q <= idx_sum;
                            st_q  <= ST_PTR;
                        end else begin
                            done        <= 1'b1;
                            is_register <= 1'b0;
                            ea          <= idx_sum;
                            st_q        <= ST_IDLE;
                        end
                    end
                end
                ST_PTR: begin
                    if (mem_ack) begin
                        done        <= 1'b1;
                        is_register <= 1'b0;
                        ea          <= mem_rdata;
                        st_q        <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // R1: no memory traffic from the idle state
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_IDLE |-> !mem_req);

    // R2: a register operand never comes with a write-back
    a_r2_direct_no_wb: assert property (@(posedge clk) disable iff (rst)
        done && is_register |-> !reg_wr_en);

    // R9: the index fetch advances the PC by one word past the fetched address
    a_r9_pc_advance: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_XFETCH && mem_ack |=> reg_wr_en && reg_wr_idx == PC_R
            && reg_wr_data == $past(mem_addr) + word_t'(WORD_BYTES));

    // R10: the deferred pointer word becomes the address
    a_r10_ptr_result: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_PTR && mem_ack |=> done && !is_register && ea == $past(mem_rdata));

    // R11: request held with a steady address until acknowledged
    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    // R12: a start while busy produces no completion on its own
    a_r12_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        start && st_q != ST_IDLE && !mem_ack |=> !done);

endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
    import opnd_pkg::*;
#(
    parameter int unsigned SP_IDX = 6,
    parameter int unsigned PC_IDX = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SPEC_W-1:0] spec,
    input  logic              byte_op,
    output logic [REG_W-1:0]  reg_rd_idx,
    input  logic [WORD_W-1:0] reg_rd_data,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [WORD_W-1:0] ea,
    output logic              is_register,
    output logic              reg_wr_en,
    output logic [REG_W-1:0]  reg_wr_idx,
    output logic [WORD_W-1:0] reg_wr_data
);
    spec_dec_t dec;
    word_t     use_addr, new_val;

    opnd_decode #(.SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) u_decode (
        .spec    (spec),
        .byte_op (byte_op),
        .dec     (dec)
    );

    opnd_ptr_update u_ptr (
        .kind     (dec.kind),
        .step     (dec.step),
        .rval     (reg_rd_data),
        .use_addr (use_addr),
        .new_val  (new_val)
    );

    opnd_seq #(.PC_IDX(PC_IDX)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .dec_kind    (dec.kind),
        .dec_defer   (dec.defer),
        .dec_rn      (dec.rn),
        .use_addr    (use_addr),
        .new_val     (new_val),
        .reg_rd_idx  (reg_rd_idx),
        .reg_rd_data (reg_rd_data),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .done        (done),
        .ea          (ea),
        .is_register (is_register),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_idx  (reg_wr_idx),
        .reg_wr_data (reg_wr_data)
    );
endmodule

// File: tb/opnd_ea_gen_bench.sv
`timescale 1ns/1ps
module opnd_ea_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  spec = '0;
    logic        byte_op = 1'b0;
    logic [2:0]  reg_rd_idx;
    logic [15:0] reg_rd_data;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        done, is_register, reg_wr_en;
    logic [15:0] ea, reg_wr_data;
    logic [2:0]  reg_wr_idx;

    int checks = 0;
    int failures = 0;
    int ack_lat = 1;
    int ack_cnt = 0;
    string cur_tag = "R1";

    logic [15:0] rf [8];
    assign reg_rd_data = rf[reg_rd_idx];

    always #2.5 clk = ~clk;

    opnd_ea_gen u_opnd_ea_gen (
        .clk(clk), .rst(rst), .start(start), .spec(spec), .byte_op(byte_op),
        .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .ea(ea), .is_register(is_register),
        .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data)
    );

    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h00F0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // register file: external to the block, written by its strobe
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) rf[i] <= 16'h1000 + 16'(i << 8);
        end else if (reg_wr_en) begin
            rf[reg_wr_idx] <= reg_wr_data;
        end
    end

    // memory responder with programmable latency
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
            ack_cnt <= 0;
        end else if (mem_req && !rst) begin
            if (ack_cnt >= ack_lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= memf(mem_addr);
                ack_cnt   <= 0;
            end else begin
                ack_cnt <= ack_cnt + 1;
            end
        end else begin
            ack_cnt <= 0;
        end
    end

    // behavioural reference: phase 0 idle, 1 pc read, 2 index fetch, 3 pointer read
    int          ph = 0;
    logic [2:0]  m_mode, m_r;
    logic [15:0] m_base, m_pc, m_ptr, m_val, m_sum, m_step;
    logic        x_done, x_isreg, x_wr;
    logic [15:0] x_ea, x_wdata;
    logic [2:0]  x_widx;

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; x_done = 0; x_wr = 0; x_isreg = 0;
            x_ea = 0; x_wdata = 0; x_widx = 0;
        end else begin
            x_done = 0;
            x_wr = 0;
            if (ph == 0) begin
                if (start) begin
                    m_mode = spec[5:3];
                    m_r    = spec[2:0];
                    m_val  = rf[m_r];
                    m_step = (byte_op && m_r < 3'd6) ? 16'd1 : 16'd2;
                    case (m_mode)
                        3'd0: begin x_done = 1; x_isreg = 1; x_ea = {13'd0, m_r}; end
                        3'd1: begin x_done = 1; x_isreg = 0; x_ea = m_val; end
                        3'd2: begin x_done = 1; x_isreg = 0; x_ea = m_val;
                                    x_wr = 1; x_widx = m_r; x_wdata = m_val + m_step; end
                        3'd4: begin x_done = 1; x_isreg = 0; x_ea = m_val - m_step;
                                    x_wr = 1; x_widx = m_r; x_wdata = m_val - m_step; end
                        3'd3: begin x_wr = 1; x_widx = m_r; x_wdata = m_val + 16'd2;
                                    m_ptr = m_val; ph = 3; end
                        3'd5: begin x_wr = 1; x_widx = m_r; x_wdata = m_val - 16'd2;
                                    m_ptr = m_val - 16'd2; ph = 3; end
                        default: begin m_base = m_val; ph = 1; end
                    endcase
                end
            end else if (ph == 1) begin
                m_pc = rf[7];
                ph = 2;
            end else if (ph == 2) begin
                if (mem_ack) begin
                    x_wr = 1; x_widx = 3'd7; x_wdata = m_pc + 16'd2;
                    m_sum = ((m_r == 3'd7) ? m_pc + 16'd2 : m_base) + mem_rdata;
                    if (m_mode == 3'd6) begin
                        x_done = 1; x_isreg = 0; x_ea = m_sum; ph = 0;
                    end else begin
                        m_ptr = m_sum; ph = 3;
                    end
                end
            end else begin
                if (mem_ack) begin
                    x_done = 1; x_isreg = 0; x_ea = mem_rdata; ph = 0;
                end
            end
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(done == x_done, cur_tag, "done", 16'(done), 16'(x_done));
            chk(reg_wr_en == x_wr, cur_tag, "reg_wr_en", 16'(reg_wr_en), 16'(x_wr));
            if (x_wr) begin
                chk(reg_wr_idx == x_widx, cur_tag, "reg_wr_idx", 16'(reg_wr_idx), 16'(x_widx));
                chk(reg_wr_data == x_wdata, cur_tag, "reg_wr_data", reg_wr_data, x_wdata);
            end
            if (x_done) begin
                chk(ea == x_ea, cur_tag, "ea", ea, x_ea);
                chk(is_register == x_isreg, cur_tag, "is_register", 16'(is_register), 16'(x_isreg));
            end
            // R11: request and address follow the model's phase
            chk(mem_req == (ph == 2 || ph == 3), "R11", "mem_req", 16'(mem_req), 16'(ph == 2 || ph == 3));
            if (ph == 2 || ph == 3)
                chk(mem_addr == ((ph == 2) ? m_pc : m_ptr), "R11", "mem_addr", mem_addr,
                    (ph == 2) ? m_pc : m_ptr);
        end
    end

    task automatic run_op(input logic [2:0] mode, input logic [2:0] r, input bit b,
                          input logic [15:0] exp_ea, input bit exp_isreg,
                          input string tag, input bit intrude);
        int n = 0;
        int extra = -1;
        int ndone = 0;
        logic [15:0] got = '0;
        logic got_reg = 1'b0;
        cur_tag = tag;
        @(negedge clk);
        start = 1'b1; spec = {mode, r}; byte_op = b;
        @(negedge clk);
        start = 1'b0;
        while (n < 60 && (ndone == 0 || extra < 3)) begin
            if (done) begin ndone++; got = ea; got_reg = is_register; end
            if (ndone > 0) extra++;
            if (intrude && n == 1) begin
                start = 1'b1; spec = 6'o03;   // R12: mode 0 request while busy
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(ndone == 1, tag, "done count", 16'(ndone), 16'd1);
        chk(got == exp_ea, tag, "ea result", got, exp_ea);
        chk(got_reg == exp_isreg, tag, "is_register result", 16'(got_reg), 16'(exp_isreg));
    endtask

    initial begin
        #400000ns;
        failures++;
        checks++;
        $display("FAIL watchdog R11 act=%h exp=%h", 16'd0, 16'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] p;
        repeat (3) @(negedge clk);
        // R1: quiet outputs under reset
        chk(done == 0, "R1", "done in reset", 16'(done), 0);
        chk(reg_wr_en == 0, "R1", "reg_wr_en in reset", 16'(reg_wr_en), 0);
        chk(mem_req == 0, "R1", "mem_req in reset", 16'(mem_req), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 0 && reg_wr_en == 0 && mem_req == 0, "R1", "after reset",
            16'({done, reg_wr_en, mem_req}), 0);

        run_op(3'd0, 3'd3, 1'b0, 16'h0003, 1'b1, "R2", 1'b0);
        chk(rf[3] == 16'h1300, "R2", "R3 untouched", rf[3], 16'h1300);
        run_op(3'd1, 3'd2, 1'b0, 16'h1200, 1'b0, "R3", 1'b0);
        chk(rf[2] == 16'h1200, "R3", "R2 untouched", rf[2], 16'h1200);

        run_op(3'd2, 3'd1, 1'b0, 16'h1100, 1'b0, "R4", 1'b0);
        chk(rf[1] == 16'h1102, "R4", "word post-inc", rf[1], 16'h1102);
        run_op(3'd2, 3'd1, 1'b1, 16'h1102, 1'b0, "R4", 1'b0);
        chk(rf[1] == 16'h1103, "R4", "byte post-inc", rf[1], 16'h1103);

        run_op(3'd4, 3'd4, 1'b1, 16'h13FF, 1'b0, "R5", 1'b0);
        chk(rf[4] == 16'h13FF, "R5", "byte pre-dec", rf[4], 16'h13FF);
        run_op(3'd4, 3'd4, 1'b0, 16'h13FD, 1'b0, "R5", 1'b0);
        chk(rf[4] == 16'h13FD, "R5", "word pre-dec", rf[4], 16'h13FD);

        run_op(3'd2, 3'd6, 1'b1, 16'h1600, 1'b0, "R6", 1'b0);
        chk(rf[6] == 16'h1602, "R6", "SP byte post-inc by 2", rf[6], 16'h1602);
        run_op(3'd4, 3'd7, 1'b1, 16'h16FE, 1'b0, "R6", 1'b0);
        chk(rf[7] == 16'h16FE, "R6", "PC byte pre-dec by 2", rf[7], 16'h16FE);

        ack_lat = 0;
        run_op(3'd3, 3'd5, 1'b1, memf(16'h1500), 1'b0, "R7", 1'b0);
        chk(rf[5] == 16'h1502, "R7", "deferred inc by 2", rf[5], 16'h1502);
        run_op(3'd5, 3'd2, 1'b0, memf(16'h11FE), 1'b0, "R8", 1'b0);
        chk(rf[2] == 16'h11FE, "R8", "deferred dec by 2", rf[2], 16'h11FE);

        ack_lat = 2;
        p = rf[7];
        run_op(3'd6, 3'd3, 1'b0, 16'h1300 + memf(p), 1'b0, "R9", 1'b0);
        chk(rf[7] == p + 16'd2, "R9", "PC advanced", rf[7], p + 16'd2);
        p = rf[7];
        run_op(3'd6, 3'd7, 1'b0, p + 16'd2 + memf(p), 1'b0, "R9", 1'b0);
        chk(rf[7] == p + 16'd2, "R9", "PC-relative base", rf[7], p + 16'd2);

        p = rf[7];
        run_op(3'd7, 3'd0, 1'b0, memf(16'h1000 + memf(p)), 1'b0, "R10", 1'b0);
        chk(rf[7] == p + 16'd2, "R10", "PC advanced", rf[7], p + 16'd2);

        ack_lat = 5;
        p = rf[7];
        run_op(3'd7, 3'd1, 1'b0, memf(16'h1103 + memf(p)), 1'b0, "R11", 1'b0);

        ack_lat = 4;
        run_op(3'd3, 3'd6, 1'b1, memf(16'h1602), 1'b0, "R12", 1'b1);
        chk(rf[6] == 16'h1604, "R12", "SP after ignored start", rf[6], 16'h1604);
        chk(rf[3] == 16'h1300, "R12", "no stray op", rf[3], 16'h1300);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule